// File: doc/BRIEF.md
# Receive Graceful Stop Gate

The gate sits between a MAC that delivers received bytes and the front end of a receive DMA. It finds each frame by hunting for a run of preamble bytes closed by a start-of-frame delimiter. It then forwards the frame bytes to the buffer logic with one cycle of latency. For each frame it also issues a descriptor-advance strobe when the frame starts and a buffer-close strobe when it ends. The preamble and the delimiter are consumed and never forwarded.

Software asks for a clean halt by raising `stop_req`. A frame already under way is allowed to run to a valid end. At that point its buffer is closed and the sticky event bit `stop_evt` is raised, which also serves as the interrupt. If no frame is in progress, the halt is immediate. While the request stays high, every incoming byte is dropped, even if the MAC keeps delivering. Once the request drops, the gate does not resume in the middle of a frame: it hunts again for a full preamble and delimiter, and the first frame it accepts is steered to the next descriptor.

The controller has five states. `ST_HUNT` hunts with no stop pending. `ST_PASS` forwards a frame. `ST_DRAIN` forwards a frame while a stop is pending. `ST_DHUNT` hunts with a stop pending, after a frame that ended in error. `ST_HALT` discards all input. The transitions are as follows:
- HUNT→HALT on a stop request.
- HUNT→PASS on a delimiter hit.
- PASS→DRAIN on a stop request in mid-frame.
- DRAIN→PASS when the request drops.
- PASS/DRAIN→HUNT on an end of frame with no stop request.
- PASS/DRAIN→HALT on a clean end of frame with a stop request.
- PASS/DRAIN→DHUNT on an errored end of frame with a stop request.
- DHUNT→DRAIN or DHUNT→PASS on a delimiter hit (DRAIN if the request is still high).
- DHUNT→HUNT when the request drops.
- HALT→HUNT when the request drops.

Top module: `rx_stop_gate`

## Requirements
- R1: After reset, every output is low and the gate hunts for a preamble with no stop pending.
- R2: A frame opens only after at least PRE_MIN (7) consecutive 0x55 bytes followed by 0xD5. Every following byte is output one cycle after its input. `out_sof` marks the first data byte, and `desc_adv` pulses for one cycle, one cycle after the 0xD5 byte. The preamble and delimiter bytes are never output.
- R3: A preamble with fewer than PRE_MIN bytes of 0x55, or one broken by any other byte, restarts the count, and no bytes are forwarded.
- R4: A stop request raised during a frame lets the frame complete. On its clean end (`in_eof` high with `in_err` low), `buf_close`, `out_eof` and `stop_evt` all rise in the same cycle.
- R5: While `stop_req` stays high after the halt, no input byte is forwarded and no strobe is issued, even for a well-formed frame.
- R6: A stop request raised with no frame in progress sets `stop_evt` one cycle later, with no `buf_close`.
- R7: An end of frame with `in_err` high closes the buffer (`buf_close` and `out_err` high) but does not complete a pending stop. The next frame is accepted, and its clean end completes the stop.
- R8: `stop_evt` stays high until a cycle with `evt_clr` high clears it. Clearing it does not release the stop. A set in the same cycle as a clear wins.
- R9: After `stop_req` drops, bytes of a frame already under way are not forwarded. Forwarding resumes only after a new full preamble and delimiter, with a fresh `desc_adv`.
- R10: Each accepted frame gives exactly one `desc_adv` and exactly one `buf_close`. A one-byte frame carries `out_sof` and `out_eof` on the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte from the MAC |
| in_eof | input | 1 | Input byte is the last byte of a frame |
| in_err | input | 1 | The frame ending on this byte is in error |
| stop_req | input | 1 | Software stop request (level) |
| evt_clr | input | 1 | Write-1-to-clear strobe for stop_evt |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_sof | output | 1 | First data byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_err | output | 1 | Frame closed in error |
| desc_adv | output | 1 | Advance to the next receive descriptor |
| buf_close | output | 1 | Close the current frame buffer |
| stop_evt | output | 1 | Sticky stop-complete event (interrupt) |

## Verification
The bench builds the gate with its defaults: PRE_MIN of 7, a preamble byte of 0x55 and a delimiter byte of 0xD5. With these values, both a six-byte preamble, which is one short of the minimum, and a preamble broken just before the delimiter are in reach. The directed scenarios place the stop request in each controller state: idle hunting, mid-frame, after an errored end, and release while a frame is still on the wire. They also cover a set colliding with a clear of the event bit.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_PASS,
        ST_DRAIN,
        ST_DHUNT,
        ST_HALT
    } rsg_state_t;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/rsg_preamble_hunter.sv
module rsg_preamble_hunter #(
    parameter int unsigned PRE_MIN  = 7,
    parameter logic [7:0]  PRE_BYTE = 8'h55,
    parameter logic [7:0]  SFD_BYTE = 8'hD5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hunting,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       sfd_hit
);
    localparam int unsigned CNT_W = $clog2(PRE_MIN + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PRE_MIN);

    logic [CNT_W-1:0] run_cnt;

    // run of preamble bytes, saturating at the minimum length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!hunting) begin
            run_cnt <= '0;
        end else if (in_valid) begin
            if (in_data == PRE_BYTE) begin
                if (run_cnt < CNT_TOP) begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

    assign sfd_hit = hunting && in_valid && (in_data == SFD_BYTE) && (run_cnt == CNT_TOP);

    // R3: a stray byte always restarts the preamble count
    a_r3_stray_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data != PRE_BYTE) |=> (run_cnt == '0));

endmodule

// File: rtl/rsg_stop_event.sv
module rsg_stop_event (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic evt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt <= 1'b0;
        end else if (set_evt) begin
            evt <= 1'b1;
        end else if (clr_evt) begin
            evt <= 1'b0;
        end
    end

    // R8: sticky until written, set beats clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !clr_evt) |=> evt);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !evt);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> evt);

endmodule

// File: rtl/rsg_fsm.sv
module rsg_fsm
    import rsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_eof,
    input  logic              in_err,
    input  logic              stop_req,
    input  logic              sfd_hit,
    output logic              hunting,
    output logic              halt_entry,
    output rsg_state_t        state_o,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_err,
    output logic              desc_adv,
    output logic              buf_close
);
    rsg_state_t state, nxt;
    logic       fwd;
    logic       fin;
    logic       frame_start;
    logic       first_pend;
    rsg_state_t fin_dest;

    assign hunting = (state == ST_HUNT) || (state == ST_DHUNT);
    assign fwd     = in_valid && ((state == ST_PASS) || (state == ST_DRAIN));
    assign fin     = in_valid && in_eof;
    assign state_o = state;

    always_comb begin
        if (!stop_req) begin
            fin_dest = ST_HUNT;
        end else if (in_err) begin
            fin_dest = ST_DHUNT;
        end else begin
            fin_dest = ST_HALT;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT: begin
                if (stop_req) begin
                    nxt = ST_HALT;
                end else if (sfd_hit) begin
                    nxt = ST_PASS;
                end
            end
            ST_PASS: begin
                if (fin) begin
                    nxt = fin_dest;
                end else if (stop_req) begin
                    nxt = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (fin) begin
                    nxt = fin_dest;
                end else if (!stop_req) begin
                    nxt = ST_PASS;
                end
            end
            ST_DHUNT: begin
                if (sfd_hit) begin
                    nxt = stop_req ? ST_DRAIN : ST_PASS;
                end else if (!stop_req) begin
                    nxt = ST_HUNT;
                end
            end
            ST_HALT: begin
                if (!stop_req) begin
                    nxt = ST_HUNT;
                end
            end
            default: nxt = ST_HUNT;
        endcase
    end

    assign frame_start = hunting && ((nxt == ST_PASS) || (nxt == ST_DRAIN));
    assign halt_entry  = (nxt == ST_HALT) && (state != ST_HALT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            state <= nxt;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_sof    <= 1'b0;
            out_eof    <= 1'b0;
            out_err    <= 1'b0;
            desc_adv   <= 1'b0;
            buf_close  <= 1'b0;
            first_pend <= 1'b0;
        end else begin
            out_valid <= fwd;
            out_data  <= fwd ? in_data : '0;
            out_sof   <= fwd && first_pend;
            out_eof   <= fwd && in_eof;
            out_err   <= fwd && in_eof && in_err;
            buf_close <= fwd && in_eof;
            desc_adv  <= frame_start;
            if (frame_start) begin
                first_pend <= 1'b1;
            end else if (fwd) begin
                first_pend <= 1'b0;
            end
        end
    end

    // R5: nothing leaves the gate while halted
    a_r5_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (!out_valid && !desc_adv && !buf_close));

    // R2: no byte is forwarded from a hunting state
    a_r2_hunt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        hunting |=> !out_valid);

endmodule

// File: rtl/rx_stop_gate.sv
module rx_stop_gate
    import rsg_pkg::*;
#(
    parameter int unsigned PRE_MIN  = 7,
    parameter logic [7:0]  PRE_BYTE = 8'h55,
    parameter logic [7:0]  SFD_BYTE = 8'hD5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_eof,
    input  logic       in_err,
    input  logic       stop_req,
    input  logic       evt_clr,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof,
    output logic       out_err,
    output logic       desc_adv,
    output logic       buf_close,
    output logic       stop_evt
);
    logic       hunting;
    logic       sfd_hit;
    logic       halt_entry;
    rsg_state_t st;
    logic       in_frame;

    rsg_preamble_hunter #(
        .PRE_MIN (PRE_MIN),
        .PRE_BYTE(PRE_BYTE),
        .SFD_BYTE(SFD_BYTE)
    ) u_hunt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hunting (hunting),
        .in_valid(in_valid),
        .in_data (in_data),
        .sfd_hit (sfd_hit)
    );

    rsg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_eof    (in_eof),
        .in_err    (in_err),
        .stop_req  (stop_req),
        .sfd_hit   (sfd_hit),
        .hunting   (hunting),
        .halt_entry(halt_entry),
        .state_o   (st),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sof   (out_sof),
        .out_eof   (out_eof),
        .out_err   (out_err),
        .desc_adv  (desc_adv),
        .buf_close (buf_close)
    );

    rsg_stop_event u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(halt_entry),
        .clr_evt(evt_clr),
        .evt    (stop_evt)
    );

    assign in_frame = (st == ST_PASS) || (st == ST_DRAIN);

    // R4: clean end under stop closes the buffer and raises the event together
    a_r4_clean_end_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && in_valid && in_eof && !in_err && stop_req) |=> (buf_close && out_eof && stop_evt));

    // R6: stop while idle completes at once without a close
    a_r6_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HUNT) && stop_req) |=> (stop_evt && !buf_close));

    // R7: an errored end never completes the stop
    a_r7_err_end_no_evt: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && in_valid && in_eof && in_err && !stop_evt) |=> (!stop_evt && out_err));

endmodule

// File: tb/rx_stop_gate_tb_top.sv
module rx_stop_gate_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_eof = 1'b0;
    logic       in_err = 1'b0;
    logic       stop_req = 1'b0;
    logic       evt_clr = 1'b0;
    logic       out_valid, out_sof, out_eof, out_err, desc_adv, buf_close, stop_evt;
    logic [7:0] out_data;

    int total = 0;
    int bad = 0;
    bit ended = 1'b0;

    int rx_n, sof_n, close_n, adv_n, err_n, closeevt_n;
    logic [7:0] rx_buf [64];

    always #2 clk = ~clk;

    rx_stop_gate dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_eof(in_eof), .in_err(in_err), .stop_req(stop_req), .evt_clr(evt_clr),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .out_err(out_err), .desc_adv(desc_adv),
        .buf_close(buf_close), .stop_evt(stop_evt)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (rx_n < 64) rx_buf[rx_n] = out_data;
                rx_n++;
            end
            if (out_sof) sof_n++;
            if (buf_close) close_n++;
            if (desc_adv) adv_n++;
            if (out_err) err_n++;
            if (buf_close && stop_evt) closeevt_n++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    task automatic zero_counts();
        rx_n = 0; sof_n = 0; close_n = 0; adv_n = 0; err_n = 0; closeevt_n = 0;
    endtask

    task automatic drive(input bit v, input logic [7:0] d, input bit e, input bit r);
        @(negedge clk);
        in_valid = v; in_data = d; in_eof = e; in_err = r;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic send_head(input int npre);
        for (int i = 0; i < npre; i++) drive(1'b1, 8'h55, 1'b0, 1'b0);
        drive(1'b1, 8'hD5, 1'b0, 1'b0);
    endtask

    task automatic send_data(input int len, input logic [7:0] base, input bit last_eof, input bit err);
        for (int i = 0; i < len; i++)
            drive(1'b1, base + 8'(i), last_eof && (i == len - 1), err && last_eof && (i == len - 1));
    endtask

    task automatic send_frame(input int npre, input int len, input logic [7:0] base);
        send_head(npre);
        send_data(len, base, 1'b1, 1'b0);
    endtask

    task automatic pulse_clr();
        @(negedge clk); evt_clr = 1'b1;
        @(negedge clk); evt_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // R1
    task automatic t_reset();
        check_eq("R1 out_valid", int'(out_valid), 0);
        check_eq("R1 strobes", int'(desc_adv | buf_close | out_sof | out_eof), 0);
        check_eq("R1 stop_evt", int'(stop_evt), 0);
    endtask

    // R2, R10
    task automatic t_normal();
        zero_counts();
        send_frame(7, 5, 8'h20);
        idle(2);
        check_eq("R2 bytes forwarded", rx_n, 5);
        check_eq("R2 first byte", int'(rx_buf[0]), 'h20);
        check_eq("R2 last byte", int'(rx_buf[4]), 'h24);
        check_eq("R2 sof count", sof_n, 1);
        check_eq("R10 desc_adv count", adv_n, 1);
        check_eq("R10 buf_close count", close_n, 1);
        zero_counts();
        send_frame(10, 1, 8'h33);
        idle(2);
        check_eq("R10 one-byte frame bytes", rx_n, 1);
        check_eq("R10 one-byte sof", sof_n, 1);
        check_eq("R10 one-byte close", close_n, 1);
    endtask

    // R3
    task automatic t_bad_preamble();
        zero_counts();
        send_frame(6, 4, 8'h20);
        idle(2);
        check_eq("R3 short preamble bytes", rx_n, 0);
        check_eq("R3 short preamble adv", adv_n, 0);
        zero_counts();
        for (int i = 0; i < 4; i++) drive(1'b1, 8'h55, 1'b0, 1'b0);
        drive(1'b1, 8'h00, 1'b0, 1'b0);
        send_frame(3, 3, 8'h20);
        idle(2);
        check_eq("R3 broken preamble bytes", rx_n, 0);
        zero_counts();
        send_frame(7, 2, 8'h20);
        idle(2);
        check_eq("R3 recovery frame", rx_n, 2);
    endtask

    // R4, R5, R8
    task automatic t_stop_mid_frame();
        zero_counts();
        send_head(7);
        send_data(2, 8'h20, 1'b0, 1'b0);
        stop_req = 1'b1;
        send_data(3, 8'h22, 1'b1, 1'b0);
        idle(2);
        check_eq("R4 frame completed bytes", rx_n, 5);
        check_eq("R4 last byte", int'(rx_buf[4]), 'h24);
        check_eq("R4 close count", close_n, 1);
        check_eq("R4 event with close", closeevt_n, 1);
        check_eq("R4 stop_evt", int'(stop_evt), 1);
        zero_counts();
        send_frame(8, 4, 8'h30);
        idle(2);
        check_eq("R5 halted bytes", rx_n, 0);
        check_eq("R5 halted adv", adv_n, 0);
        check_eq("R5 halted close", close_n, 0);
        pulse_clr();
        check_eq("R8 cleared", int'(stop_evt), 0);
        zero_counts();
        send_frame(7, 3, 8'h30);
        idle(2);
        check_eq("R8 clear keeps stop", rx_n, 0);
        check_eq("R8 stays clear", int'(stop_evt), 0);
        stop_req = 1'b0;
        idle(2);
    endtask

    // R6, R8
    task automatic t_idle_stop();
        zero_counts();
        idle(2);
        check_eq("R6 evt before", int'(stop_evt), 0);
        stop_req = 1'b1;
        @(negedge clk);
        check_eq("R6 evt next cycle", int'(stop_evt), 1);
        check_eq("R6 no close", close_n, 0);
        stop_req = 1'b0;
        idle(2);
        pulse_clr();
        idle(1);
        check_eq("R8 cleared after idle stop", int'(stop_evt), 0);
        stop_req = 1'b1;
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
        check_eq("R8 set beats clear", int'(stop_evt), 1);
        idle(2);
        check_eq("R8 sticky", int'(stop_evt), 1);
        stop_req = 1'b0;
        idle(2);
        pulse_clr();
    endtask

    // R7
    task automatic t_error_end();
        zero_counts();
        send_head(7);
        send_data(2, 8'h20, 1'b0, 1'b0);
        stop_req = 1'b1;
        send_data(2, 8'h22, 1'b1, 1'b1);
        idle(2);
        check_eq("R7 errored close", close_n, 1);
        check_eq("R7 out_err", err_n, 1);
        check_eq("R7 no completion", int'(stop_evt), 0);
        send_frame(7, 3, 8'h40);
        idle(2);
        check_eq("R7 next frame accepted", rx_n, 7);
        check_eq("R7 completion on clean end", int'(stop_evt), 1);
        check_eq("R7 event with close", closeevt_n, 1);
        stop_req = 1'b0;
        idle(2);
        pulse_clr();
    endtask

    // R9
    task automatic t_release_rehunt();
        stop_req = 1'b1;
        idle(2);
        zero_counts();
        send_head(7);
        send_data(2, 8'h20, 1'b0, 1'b0);
        stop_req = 1'b0;
        send_data(3, 8'h22, 1'b1, 1'b0);
        idle(2);
        check_eq("R9 mid-frame bytes dropped", rx_n, 0);
        check_eq("R9 no close mid-frame", close_n, 0);
        check_eq("R9 no adv mid-frame", adv_n, 0);
        send_frame(7, 2, 8'h60);
        idle(2);
        check_eq("R9 new frame bytes", rx_n, 2);
        check_eq("R9 new frame data", int'(rx_buf[0]), 'h60);
        check_eq("R9 new descriptor", adv_n, 1);
        pulse_clr();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        zero_counts();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_bad_preamble();
        t_stop_mid_frame();
        t_idle_stop();
        t_error_end();
        t_release_rehunt();
        idle(2);
        finish_run();
    end

endmodule